// File: doc/BRIEF.md
# Right-to-Left Montgomery Modular Exponentiator

This block raises a base X to an H-bit power E modulo an odd K-bit modulus N, using Montgomery arithmetic with R = 2^(K+2). The caller also supplies W = R^2 mod N, which is computed elsewhere. Two bit-serial Montgomery multiplier lanes work side by side. Each uses a radix-2 add-shift routine and takes one operand bit per cycle. Both lanes share a single right-hand operand.

A run begins with a setup pass that converts X and 1 into residue form. Both conversions multiply by W. Then comes one pass per exponent bit, scanning from the least significant end. In each pass one lane squares the running power Z while the other lane multiplies the accumulator P by the same old Z. The new P is kept only when the current exponent bit is set. A last pass multiplies P by 1, which converts it back to ordinary form. That value is already below N, so it goes straight to the output with no correcting subtraction.

The caller applies operands and pulses `start` while the block is idle. `busy` stays high for the whole run. `done` marks the single cycle in which `result` first holds the answer.

Top module: `mont_modexp`

## Requirements
- R1: For odd N < 2^K, X < N with gcd(X, N) = 1, any H-bit E and W = 2^(2(K+2)) mod N, `result` equals X^E mod N when `done` is high.
- R2: The delivered `result` is strictly less than N, and no reduction step follows the final conversion pass.
- R3: An all-zero exponent gives `result` = 1 (for N > 1).
- R4: An exponent equal to 1 gives `result` = X.
- R5: All H exponent bits are scanned from bit 0 upward, whatever their values. `done` therefore rises exactly (H+2)*(K+5) clock cycles after the edge that samples `start`.
- R6: `done` is high for exactly one cycle, `busy` is also high in that cycle, and `busy` is low in the cycle after it.
- R7: A `start` pulse while `busy` is high is ignored. The running job keeps its operands, its result and its timing.
- R8: After reset, `busy`, `done` and `result` are all 0.
- R9: While idle, `result` keeps the last answer, even if the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new exponentiation; sampled only while idle |
| modulus | input | K | Odd modulus N |
| base | input | K | Base X, below N |
| exponent | input | H | Exponent E |
| rSquare | input | K | Precomputed 2^(2(K+2)) mod N |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | K | X^E mod N, held until the next run completes |

## Verification
The bench compares every run against a software square-and-multiply model, and computes W itself by repeated doubling. The chosen cases target specific failures:
- Zero and unit exponents would show a P lane that was never initialised to the residue of 1, or that updated on clear bits.
- All-ones exponents and random exponents with scattered clear bits would expose a squaring that used the new Z instead of the old one, or a bit order taken from the wrong end.
- The smallest and largest moduli would show a missing guard bit, as wrong values or a result of N or more.
- A start pulse injected mid-run would show a controller that reloads operands.

A fixed cycle count per run catches a miscounted step or exponent loop.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  typedef enum logic [1:0] {
    OP_SETUP  = 2'd0,
    OP_SQUARE = 2'd1,
    OP_FINAL  = 2'd2
  } opKind_t;

  typedef struct packed {
    logic    load;     // capture operands at start
    logic    opStart;  // prime lane operands, clear accumulators
    logic    step;     // one add-shift iteration in both lanes
    logic    commit;   // write lane results back to Z / P
    opKind_t op;       // which pass is in flight
  } ctrlStrobe_t;

endpackage

// File: rtl/mont_step.sv
module mont_step #(
  parameter int AW = 20
) (
  input  logic [AW-1:0] accIn,
  input  logic [AW-1:0] nIn,
  input  logic [AW-1:0] bIn,
  input  logic          aBit,
  output logic [AW-1:0] accOut
);
  logic [AW:0] sum;

  always_comb begin
    // make the accumulator even, halve it, then add the selected multiple of B
    sum    = {1'b0, accIn} + (accIn[0] ? {1'b0, nIn} : '0);
    accOut = AW'(sum >> 1) + (aBit ? bIn : '0);
  end
endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_pkg::*;
#(
  parameter int K = 16,
  parameter int H = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strb,
  output logic        busy,
  output logic        done
);
  localparam int STEPS = K + 3;
  localparam int ITW   = $clog2(STEPS) + 1;
  localparam int BCW   = $clog2(H) + 1;

  typedef enum logic [2:0] {S_IDLE, S_BEGIN, S_RUN, S_COMMIT, S_DONE} state_t;

  state_t          state;
  opKind_t         opReg;
  logic [ITW-1:0]  iter;
  logic [BCW-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      opReg  <= OP_SETUP;
      iter   <= '0;
      bitCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_BEGIN;
          opReg <= OP_SETUP;
        end
        S_BEGIN: begin
          iter  <= '0;
          state <= S_RUN;
        end
        S_RUN: begin
          iter <= iter + 1'b1;
          if (iter == ITW'(STEPS - 1)) state <= S_COMMIT;
        end
        S_COMMIT: begin
          unique case (opReg)
            OP_SETUP: begin
              opReg  <= OP_SQUARE;
              bitCnt <= '0;
              state  <= S_BEGIN;
            end
            OP_SQUARE: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == BCW'(H - 1)) opReg <= OP_FINAL;
              state <= S_BEGIN;
            end
            default: state <= S_DONE;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = (state == S_IDLE) && start;
    strb.opStart = (state == S_BEGIN);
    strb.step    = (state == S_RUN);
    strb.commit  = (state == S_COMMIT);
    strb.op      = opReg;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  p_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && strb.opStart && strb.op == OP_SETUP));
  p_no_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.load);
endmodule

// File: rtl/modexp_dp.sv
module modexp_dp
  import modexp_pkg::*;
#(
  parameter int K = 16,
  parameter int H = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic [K-1:0] modulus,
  input  logic [K-1:0] base,
  input  logic [H-1:0] exponent,
  input  logic [K-1:0] rSquare,
  output logic [K-1:0] result
);
  localparam int AW    = K + 4;  // covers partial sums up to about 6N
  localparam int LANES = 2;      // lane 0: square Z, lane 1: multiply P

  logic [AW-1:0] nReg, xReg, wReg, zReg, pReg, bReg;
  logic [H-1:0]  expShift;
  logic [AW-1:0] aShift  [LANES];
  logic [AW-1:0] acc     [LANES];
  logic [AW-1:0] nextAcc [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mont_step #(.AW(AW)) u_step (
      .accIn (acc[g]),
      .nIn   (nReg),
      .bIn   (bReg),
      .aBit  (aShift[g][0]),
      .accOut(nextAcc[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nReg     <= '0;
      xReg     <= '0;
      wReg     <= '0;
      zReg     <= '0;
      pReg     <= '0;
      bReg     <= '0;
      expShift <= '0;
      for (int i = 0; i < LANES; i++) begin
        aShift[i] <= '0;
        acc[i]    <= '0;
      end
    end else begin
      if (strb.load) begin
        nReg     <= AW'(modulus);
        xReg     <= AW'(base);
        wReg     <= AW'(rSquare);
        expShift <= exponent;
      end
      if (strb.opStart) begin
        for (int i = 0; i < LANES; i++) acc[i] <= '0;
        unique case (strb.op)
          OP_SETUP: begin
            aShift[0] <= xReg;
            aShift[1] <= AW'(1);
            bReg      <= wReg;
          end
          OP_SQUARE: begin
            aShift[0] <= zReg;
            aShift[1] <= pReg;
            bReg      <= zReg;   // shared right operand: the old Z
          end
          default: begin
            aShift[0] <= pReg;
            aShift[1] <= pReg;
            bReg      <= AW'(1);
          end
        endcase
      end
      if (strb.step) begin
        for (int i = 0; i < LANES; i++) begin
          acc[i]    <= nextAcc[i];
          aShift[i] <= aShift[i] >> 1;
        end
      end
      if (strb.commit) begin
        unique case (strb.op)
          OP_SETUP: begin
            zReg <= acc[0];
            pReg <= acc[1];
          end
          OP_SQUARE: begin
            zReg     <= acc[0];
            if (expShift[0]) pReg <= acc[1];
            expShift <= expShift >> 1;
          end
          default: pReg <= acc[1];
        endcase
      end
    end
  end

  assign result = pReg[K-1:0];

  p_result_below_n_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.op == OP_FINAL) |=> (pReg < nReg));
  p_clear_bit_keeps_p_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.op == OP_SQUARE && !expShift[0]) |=> $stable(pReg));
  p_operands_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step || strb.commit) |=> ($stable(nReg) && $stable(xReg)));
endmodule

// File: rtl/mont_modexp.sv
module mont_modexp
  import modexp_pkg::*;
#(
  parameter int K = 16,
  parameter int H = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [K-1:0] modulus,
  input  logic [K-1:0] base,
  input  logic [H-1:0] exponent,
  input  logic [K-1:0] rSquare,
  output logic         busy,
  output logic         done,
  output logic [K-1:0] result
);
  ctrlStrobe_t strb;

  modexp_ctrl #(.K(K), .H(H)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .strb (strb),
    .busy (busy),
    .done (done)
  );

  modexp_dp #(.K(K), .H(H)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .modulus (modulus),
    .base    (base),
    .exponent(exponent),
    .rSquare (rSquare),
    .result  (result)
  );

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(result));
endmodule

// File: tb/mont_modexp_bench.sv
`timescale 1ns/1ps
module mont_modexp_bench;
  localparam int K   = 16;
  localparam int H   = 16;
  localparam int LAT = (H + 2) * (K + 5);

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [K-1:0] modulus = '0, base = '0, rSquare = '0;
  logic [H-1:0] exponent = '0;
  logic         busy, done;
  logic [K-1:0] result;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  mont_modexp #(.K(K), .H(H)) u_mont_modexp (
    .clk(clk), .rstN(rstN), .start(start), .modulus(modulus), .base(base),
    .exponent(exponent), .rSquare(rSquare), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint modPow(input longint x, input longint e, input longint n);
    longint r = 1 % n;
    longint b = x % n;
    for (int i = 0; i < H; i++) begin
      if (e[i]) r = (r * b) % n;
      b = (b * b) % n;
    end
    return r;
  endfunction

  function automatic longint calcW(input longint n);
    longint w = 1;
    for (int i = 0; i < 2 * (K + 2); i++) w = (w * 2) % n;
    return w;
  endfunction

  function automatic longint gcd(input longint a, input longint b);
    longint t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  // one complete run; poke = inject a conflicting start in mid-run
  task automatic runExp(input longint n, input longint x, input longint e,
                        input bit poke, input string tag);
    int cyc = 0;
    longint want = modPow(x, e, n);
    @(negedge clk);
    modulus = K'(n); base = K'(x); exponent = H'(e); rSquare = K'(calcW(n));
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 4 * LAT) begin
      if (poke && cyc == LAT / 2) begin
        start = 1'b1; modulus = K'(n ^ 2); base = K'(1); exponent = '1;
      end else start = 1'b0;
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(result == K'(want), {tag, " R1 result"}, longint'(result), want);
    chk(longint'(result) < n, {tag, " R2 below N"}, longint'(result), n - 1);
    chk(cyc == LAT, {tag, " R5 latency"}, cyc, LAT);
    chk(busy == 1'b1, {tag, " R6 busy at done"}, busy, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {tag, " R6 one-cycle done"}, {done, busy}, 0);
  endtask

  task automatic testReset();
    chk(busy == 1'b0, "R8 busy", busy, 0);
    chk(done == 1'b0, "R8 done", done, 0);
    chk(result == '0, "R8 result", longint'(result), 0);
  endtask

  task automatic testZeroExp();
    runExp(40961, 12345, 0, 1'b0, "R3 e=0");
    chk(result == 1, "R3 unit result", longint'(result), 1);
    runExp(3, 2, 0, 1'b0, "R3 small n");
  endtask

  task automatic testOneExp();
    runExp(65521, 54321, 1, 1'b0, "R4 e=1");
    chk(result == K'(54321), "R4 equals base", longint'(result), 54321);
  endtask

  task automatic testEdges();
    runExp(65535, 2, 16'hFFFF, 1'b0, "R1 max n all-ones e");
    runExp(3, 2, 16'hFFFF, 1'b0, "R1 n=3");
    runExp(32769, 32768, 16'h8000, 1'b0, "R5 msb-only e");
    runExp(65521, 65520, 16'h0002, 1'b0, "R1 x=n-1");
  endtask

  task automatic testRandom();
    for (int t = 0; t < 12; t++) begin
      longint n = longint'(($urandom & 32'hFFFF) | 32'h8001);
      longint x;
      do x = longint'($urandom) % n; while (gcd(x, n) != 1);
      runExp(n, x, longint'($urandom & 32'hFFFF), 1'b0, "R1 random");
    end
  endtask

  task automatic testBusyStart();
    runExp(50021, 4321, 16'hA5C3, 1'b1, "R7 start while busy");
  endtask

  task automatic testHold();
    logic [K-1:0] held;
    runExp(60013, 777, 16'h1234, 1'b0, "R9 setup");
    held = result;
    modulus = 16'h1235; base = 16'h0042; exponent = 16'h0F0F; rSquare = 16'h0101;
    repeat (6) @(negedge clk);
    chk(result == held, "R9 result held", longint'(result), longint'(held));
    chk(busy == 1'b0, "R9 stays idle", busy, 0);
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroExp();
    testOneExp();
    testEdges();
    testRandom();
    testBusyStart();
    testHold();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule